// File: doc/BRIEF.md
# Linked-descriptor memory copy channel

This block is a single memory-to-memory copy engine. Its work comes from a linked list of descriptors kept in system memory. Software writes the address of the first descriptor into the next-descriptor register and then sets the enable bit.

For each descriptor, the channel reads seven words. It then moves the requested number of 32-bit words from the source address to the destination address. After that it follows the descriptor's link word to the next descriptor. A link of zero ends the chain.

Software can add work to a chain that has ended, or to one that is still running. It does this by updating the link word of the last descriptor and writing the resume bit. The channel then reads that link word again.

A small register port gives software access to control, status and the descriptor state. One word-wide memory port carries both the descriptor fetches and the data traffic. Memory reads return their data one cycle after the request.

Top module: `desc_copy_chan`

## Requirements
- R1: After reset, every register reads zero, `mem_req_o` is low and `irq_o` is low.
- R2: Fetch from an aligned base address.
  - Once the channel is enabled (control 0x00 bit 0) and the next register (0x10) holds a non-zero value, the channel forms a base address by clearing the low 5 bits of that value.
  - It reads 7 consecutive words from that base.
  - The current register (0x0C) shows the base.
  - Word 0 is loaded into the next register, word 1 into source (0x14), word 3 into destination (0x1C), word 4 into count (0x20) and word 5 into descriptor control (0x24).
  - Words 2 and 6 are ignored, and register 0x18 reads zero.
- R3: Data copy.
  - The channel copies count[23:2] words from source to destination, one word at a time in ascending order.
  - Each word is read and then written in the following cycle.
  - Count bits 1:0 and 31:24 are ignored.
- R4: A descriptor whose word count is zero makes no data read or write, but still completes.
- R5: When a descriptor completes with a non-zero link, the channel fetches the next descriptor. With a zero link and no resume pending, it sets end-of-chain (status bit 8) and goes idle.
- R6: End-of-transfer (status bit 9) is set whenever a descriptor completes. `irq_o` equals end-of-transfer ANDed with bit 4 of the control word of the descriptor that last set it.
- R7: Status bits 9 and 8 are cleared by writing 1 to them. Writing 0 leaves them unchanged.
- R8: Status bit 10 reads 1 while the channel is working on a descriptor or a resume, and 0 when it is idle.
- R9: Resume (append).
  - Writing 1 to control bit 1 makes the channel re-read word 0 of the current descriptor.
  - If that word is non-zero, the chain continues there. If it is zero, end-of-chain is set again.
  - A resume written while the chain is running is held until the chain ends.
  - Bit 1 always reads 0.
- R10: Clearing control bit 0 removes `mem_req_o` from the next cycle onwards and returns the channel to idle. Enabling it again with a zero next register starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 6 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from `reg_addr_i` |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | 32 | Memory byte address, word aligned |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rdata_i | input | 32 | Memory read data, valid the cycle after a read request |
| irq_o | output | 1 | Completion interrupt |

## Verification
The hardest case to reach from the ports is an append that arrives while a descriptor is still copying. The link word has already been fetched as zero at that point, so without the held resume the chain would stop. To reach it, the bench starts a descriptor that copies 64 words. While the copy is in progress, the bench rewrites that descriptor's link word in memory and then writes the resume bit. The scoreboard then expects the data writes of the appended descriptor to follow with no idle gap.

A second case is hard for the same reason: disabling the channel in the middle of a long copy, and then enabling it again, must not restart anything.

// File: rtl/dcc_pkg.sv
package dcc_pkg;
  localparam int unsigned REG_AW     = 6;
  localparam int unsigned DESC_WORDS = 7;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FREQ, ST_FCAP, ST_CRD, ST_CWR, ST_DONE, ST_RREQ, ST_RCAP
  } eng_state_e;

  localparam logic [REG_AW-1:0] OFS_CTRL = 6'h00;
  localparam logic [REG_AW-1:0] OFS_STAT = 6'h04;
  localparam logic [REG_AW-1:0] OFS_CUR  = 6'h0C;
  localparam logic [REG_AW-1:0] OFS_NEXT = 6'h10;
  localparam logic [REG_AW-1:0] OFS_SRC  = 6'h14;
  localparam logic [REG_AW-1:0] OFS_USRC = 6'h18;
  localparam logic [REG_AW-1:0] OFS_DST  = 6'h1C;
  localparam logic [REG_AW-1:0] OFS_BCNT = 6'h20;
  localparam logic [REG_AW-1:0] OFS_DCTL = 6'h24;

  localparam int unsigned CTRL_EN   = 0;
  localparam int unsigned CTRL_RES  = 1;
  localparam int unsigned STAT_EOC  = 8;
  localparam int unsigned STAT_EOT  = 9;
  localparam int unsigned STAT_BUSY = 10;
  localparam int unsigned DCTL_IE   = 4;

  localparam int unsigned W_LINK = 0;
  localparam int unsigned W_SRC  = 1;
  localparam int unsigned W_DST  = 3;
  localparam int unsigned W_BCNT = 4;
  localparam int unsigned W_DCTL = 5;
endpackage

// File: rtl/dcc_regs.sv
module dcc_regs
  import dcc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              enable_o,
  output logic              resume_o,
  output logic              nd_we_o,
  output logic [31:0]       nd_wdata_o,
  input  logic              busy_i,
  input  logic              eot_i,
  input  logic              eot_ie_i,
  input  logic              eoc_i,
  input  logic [31:0]       cur_i,
  input  logic [31:0]       nxt_i,
  input  logic [31:0]       src_i,
  input  logic [31:0]       dst_i,
  input  logic [31:0]       bcnt_i,
  input  logic [31:0]       dctl_i,
  output logic              irq_o
);
  logic en_q, eot_q, eoc_q, ie_q;
  logic wr_ctrl, wr_stat;

  assign wr_ctrl    = reg_we_i && (reg_addr_i == OFS_CTRL);
  assign wr_stat    = reg_we_i && (reg_addr_i == OFS_STAT);
  assign nd_we_o    = reg_we_i && (reg_addr_i == OFS_NEXT);
  assign nd_wdata_o = reg_wdata_i;
  assign resume_o   = wr_ctrl && reg_wdata_i[CTRL_RES];
  assign enable_o   = en_q;
  assign irq_o      = eot_q && ie_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      eot_q <= 1'b0;
      eoc_q <= 1'b0;
      ie_q  <= 1'b0;
    end else begin
      if (wr_ctrl) en_q <= reg_wdata_i[CTRL_EN];
      if (wr_stat && reg_wdata_i[STAT_EOT]) eot_q <= 1'b0;
      if (wr_stat && reg_wdata_i[STAT_EOC]) eoc_q <= 1'b0;
      // a new event wins over a simultaneous clear
      if (eot_i) begin
        eot_q <= 1'b1;
        ie_q  <= eot_ie_i;
      end
      if (eoc_i) eoc_q <= 1'b1;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      OFS_CTRL: reg_rdata_o[CTRL_EN] = en_q;
      OFS_STAT: begin
        reg_rdata_o[STAT_BUSY] = busy_i;
        reg_rdata_o[STAT_EOT]  = eot_q;
        reg_rdata_o[STAT_EOC]  = eoc_q;
      end
      OFS_CUR:  reg_rdata_o = cur_i;
      OFS_NEXT: reg_rdata_o = nxt_i;
      OFS_SRC:  reg_rdata_o = src_i;
      OFS_USRC: reg_rdata_o = '0;
      OFS_DST:  reg_rdata_o = dst_i;
      OFS_BCNT: reg_rdata_o = bcnt_i;
      OFS_DCTL: reg_rdata_o = dctl_i;
      default:  reg_rdata_o = '0;
    endcase
  end

  // R6
  eot_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eot_i |=> eot_q);
  // R7
  w1c_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stat && reg_wdata_i[STAT_EOT] && !eot_i) |=> !eot_q);
endmodule

// File: rtl/dcc_engine.sv
module dcc_engine
  import dcc_pkg::*;
#(
  parameter int unsigned CNT_W    = 24,
  parameter int unsigned ALIGN_LG = 5
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        enable_i,
  input  logic        resume_i,
  input  logic        nd_we_i,
  input  logic [31:0] nd_wdata_i,
  output logic        mem_req_o,
  output logic        mem_we_o,
  output logic [31:0] mem_addr_o,
  output logic [31:0] mem_wdata_o,
  input  logic [31:0] mem_rdata_i,
  output logic        busy_o,
  output logic        eot_o,
  output logic        eot_ie_o,
  output logic        eoc_o,
  output logic [31:0] cur_o,
  output logic [31:0] nxt_o,
  output logic [31:0] src_o,
  output logic [31:0] dst_o,
  output logic [31:0] bcnt_o,
  output logic [31:0] dctl_o
);
  localparam int unsigned WC_W  = CNT_W - 2;
  localparam int unsigned IDX_W = $clog2(DESC_WORDS);
  localparam logic [31:0] ALIGN_MASK = ~((32'd1 << ALIGN_LG) - 32'd1);

  eng_state_e        state_q;
  logic [31:0]       cur_q, nxt_q, src_q, dst_q, bcnt_q, dctl_q, off_q;
  logic [IDX_W-1:0]  idx_q;
  logic [WC_W-1:0]   left_q;
  logic              pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cur_q   <= '0;
      nxt_q   <= '0;
      src_q   <= '0;
      dst_q   <= '0;
      bcnt_q  <= '0;
      dctl_q  <= '0;
      off_q   <= '0;
      idx_q   <= '0;
      left_q  <= '0;
      pend_q  <= 1'b0;
    end else begin
      if (resume_i) pend_q <= 1'b1;
      if (nd_we_i)  nxt_q  <= nd_wdata_i;
      if (!enable_i) begin
        state_q <= ST_IDLE;
      end else begin
        case (state_q)
          ST_IDLE: begin
            if (nxt_q != '0) begin
              cur_q   <= nxt_q & ALIGN_MASK;
              idx_q   <= '0;
              state_q <= ST_FREQ;
            end else if (pend_q) begin
              if (cur_q != '0) state_q <= ST_RREQ;
              else             pend_q  <= 1'b0;
            end
          end
          ST_FREQ: state_q <= ST_FCAP;
          ST_FCAP: begin
            if (idx_q == IDX_W'(W_LINK)) nxt_q  <= mem_rdata_i;
            if (idx_q == IDX_W'(W_SRC))  src_q  <= mem_rdata_i;
            if (idx_q == IDX_W'(W_DST))  dst_q  <= mem_rdata_i;
            if (idx_q == IDX_W'(W_BCNT)) bcnt_q <= mem_rdata_i;
            if (idx_q == IDX_W'(W_DCTL)) dctl_q <= mem_rdata_i;
            if (idx_q == IDX_W'(DESC_WORDS - 1)) begin
              left_q  <= bcnt_q[CNT_W-1:2];
              off_q   <= '0;
              state_q <= (bcnt_q[CNT_W-1:2] == '0) ? ST_DONE : ST_CRD;
            end else begin
              idx_q   <= idx_q + IDX_W'(1);
              state_q <= ST_FREQ;
            end
          end
          ST_CRD: state_q <= ST_CWR;
          ST_CWR: begin
            off_q   <= off_q + 32'd4;
            left_q  <= left_q - WC_W'(1);
            state_q <= (left_q == WC_W'(1)) ? ST_DONE : ST_CRD;
          end
          ST_DONE: begin
            if (nxt_q != '0) begin
              cur_q   <= nxt_q & ALIGN_MASK;
              idx_q   <= '0;
              state_q <= ST_FREQ;
            end else if (pend_q) begin
              state_q <= ST_RREQ;
            end else begin
              state_q <= ST_IDLE;
            end
          end
          ST_RREQ: state_q <= ST_RCAP;
          ST_RCAP: begin
            pend_q <= 1'b0;
            nxt_q  <= mem_rdata_i;
            if (mem_rdata_i != '0) begin
              cur_q   <= mem_rdata_i & ALIGN_MASK;
              idx_q   <= '0;
              state_q <= ST_FREQ;
            end else begin
              state_q <= ST_IDLE;
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign mem_req_o = enable_i &&
                     (state_q inside {ST_FREQ, ST_CRD, ST_CWR, ST_RREQ});
  assign mem_we_o  = enable_i && (state_q == ST_CWR);

  always_comb begin
    case (state_q)
      ST_FREQ: mem_addr_o = cur_q + {{(30-IDX_W){1'b0}}, idx_q, 2'b00};
      ST_RREQ: mem_addr_o = cur_q;
      ST_CRD:  mem_addr_o = src_q + off_q;
      ST_CWR:  mem_addr_o = dst_q + off_q;
      default: mem_addr_o = '0;
    endcase
  end

  assign mem_wdata_o = (state_q == ST_CWR) ? mem_rdata_i : '0;
  assign busy_o      = (state_q != ST_IDLE);
  assign eot_o       = enable_i && (state_q == ST_DONE);
  assign eot_ie_o    = dctl_q[DCTL_IE];
  assign eoc_o       = enable_i &&
                       (((state_q == ST_DONE) && (nxt_q == '0) && !pend_q) ||
                        ((state_q == ST_RCAP) && (mem_rdata_i == '0)));
  assign cur_o  = cur_q;
  assign nxt_o  = nxt_q;
  assign src_o  = src_q;
  assign dst_o  = dst_q;
  assign bcnt_o = bcnt_q;
  assign dctl_o = dctl_q;

  // R10
  dis_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> (state_q == ST_IDLE));
  // R3
  wr_after_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> $past(mem_req_o && !mem_we_o));
  // R2
  fetch_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FREQ) |-> (cur_q[ALIGN_LG-1:0] == '0));
  // R5
  eoc_null_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoc_o && !nd_we_i) |=> (nxt_q == '0));
endmodule

// File: rtl/desc_copy_chan.sv
module desc_copy_chan
  import dcc_pkg::*;
#(
  parameter int unsigned CNT_W    = 24,
  parameter int unsigned ALIGN_LG = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [31:0]       mem_addr_o,
  output logic [31:0]       mem_wdata_o,
  input  logic [31:0]       mem_rdata_i,
  output logic              irq_o
);
  logic        enable, resume, nd_we, busy, eot, eot_ie, eoc;
  logic [31:0] nd_wdata, cur, nxt, src, dst, bcnt, dctl;

  dcc_regs u_regs (
    .clk_i, .rst_ni, .reg_we_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o,
    .enable_o(enable), .resume_o(resume), .nd_we_o(nd_we),
    .nd_wdata_o(nd_wdata), .busy_i(busy), .eot_i(eot), .eot_ie_i(eot_ie),
    .eoc_i(eoc), .cur_i(cur), .nxt_i(nxt), .src_i(src), .dst_i(dst),
    .bcnt_i(bcnt), .dctl_i(dctl), .irq_o
  );

  dcc_engine #(.CNT_W(CNT_W), .ALIGN_LG(ALIGN_LG)) u_engine (
    .clk_i, .rst_ni, .enable_i(enable), .resume_i(resume), .nd_we_i(nd_we),
    .nd_wdata_i(nd_wdata), .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o,
    .mem_rdata_i, .busy_o(busy), .eot_o(eot), .eot_ie_o(eot_ie), .eoc_o(eoc),
    .cur_o(cur), .nxt_o(nxt), .src_o(src), .dst_o(dst), .bcnt_o(bcnt),
    .dctl_o(dctl)
  );
endmodule

// File: tb/desc_copy_chan_bench.sv
`timescale 1ns/1ps
module desc_copy_chan_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        irq;

  logic [31:0] mem [0:1023];

  typedef struct packed { logic [31:0] a; logic [31:0] d; } wr_t;
  wr_t exp_q[$];
  int checks = 0;
  int fails = 0;
  int data_reads = 0;

  always #4 clk = ~clk;

  desc_copy_chan u_desc_copy_chan (
    .clk_i(clk), .rst_ni, .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .mem_req_o(mem_req),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_rdata_i(mem_rdata), .irq_o(irq)
  );

  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) mem[mem_addr[11:2]] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr[11:2]];
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: every data write is compared in order (R3)
  always @(negedge clk) begin
    if (rst_ni && mem_req && !mem_we && mem_addr < 32'h400) data_reads++;
    if (rst_ni && mem_req && mem_we) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R3 unexpected write act=%h exp=none", mem_addr);
      end else begin
        wr_t e;
        e = exp_q.pop_front();
        chk("R3 write addr", mem_addr, e.a);
        chk("R3 write data", mem_wdata, e.d);
      end
    end
  end

  function automatic logic [31:0] pat(input int i);
    return {16'(i) ^ 16'h5A5A, ~16'(i)};
  endfunction

  task automatic push_copy(input logic [31:0] src, input logic [31:0] dst, input int n);
    for (int k = 0; k < n; k++)
      exp_q.push_back('{a: dst + 32'(4*k), d: mem[src[11:2] + 10'(k)]});
  endtask

  task automatic put_desc(input logic [31:0] b, input logic [31:0] lnk, input logic [31:0] src,
                          input logic [31:0] dst, input logic [31:0] cnt, input logic [31:0] ctl);
    mem[b[11:2]]     = lnk;
    mem[b[11:2] + 1] = src;
    mem[b[11:2] + 2] = 32'hDEAD0001;
    mem[b[11:2] + 3] = dst;
    mem[b[11:2] + 4] = cnt;
    mem[b[11:2] + 5] = ctl;
    mem[b[11:2] + 6] = 32'hDEAD0006;
  endtask

  task automatic reg_wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [5:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    int n;
    repeat (6) @(negedge clk);
    n = 0;
    do begin
      reg_rd(6'h04, s);
      n++;
    end while (s[10] && n < 5000);
    if (n >= 5000) chk("R8 busy never dropped", s[10], 1'b0);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog act=hung exp=done");
    summary();
  end

  initial begin
    logic [31:0] v;
    int rd0, reqs;
    for (int i = 0; i < 1024; i++) mem[i] = pat(i);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset state
    reg_rd(6'h00, v); chk("R1 ctrl", v, 0);
    reg_rd(6'h04, v); chk("R1 status", v, 0);
    reg_rd(6'h0C, v); chk("R1 cur", v, 0);
    reg_rd(6'h10, v); chk("R1 next", v, 0);
    chk("R1 irq", irq, 0);
    chk("R1 mem_req", mem_req, 0);

    // R2 R3 R5: two-descriptor chain, unaligned start pointer, high count bits
    put_desc(32'h400, 32'h420, 32'h100, 32'h800, 32'hFF000013, 32'h4E);
    put_desc(32'h420, 32'h0, 32'h200, 32'h900, 32'h8, 32'h5E);
    push_copy(32'h100, 32'h800, 4);
    push_copy(32'h200, 32'h900, 2);
    reg_wr(6'h10, 32'h40C);
    reg_wr(6'h00, 32'h1);
    wait_idle();
    reg_rd(6'h00, v); chk("R9 resume bit reads 0", v, 32'h1);
    reg_rd(6'h04, v); chk("R5 R6 R8 status eot eoc", v, 32'h300);
    chk("R6 irq from int-enabled last desc", irq, 1);
    reg_rd(6'h0C, v); chk("R2 cur", v, 32'h420);
    reg_rd(6'h10, v); chk("R5 next", v, 0);
    reg_rd(6'h14, v); chk("R2 src", v, 32'h200);
    reg_rd(6'h18, v); chk("R2 upper src", v, 0);
    reg_rd(6'h1C, v); chk("R2 dst", v, 32'h900);
    reg_rd(6'h20, v); chk("R2 count", v, 32'h8);
    reg_rd(6'h24, v); chk("R2 dctl", v, 32'h5E);
    chk("R3 all writes seen", 32'(exp_q.size()), 0);

    // R7 write-one-to-clear
    reg_wr(6'h04, 32'h0);
    reg_rd(6'h04, v); chk("R7 zero write no effect", v, 32'h300);
    reg_wr(6'h04, 32'h200);
    reg_rd(6'h04, v); chk("R7 eot cleared only", v, 32'h100);
    chk("R6 irq follows eot", irq, 0);
    reg_wr(6'h04, 32'h100);
    reg_rd(6'h04, v); chk("R7 eoc cleared", v, 0);

    // R4 zero count descriptor
    put_desc(32'h440, 32'h0, 32'h100, 32'hE00, 32'h0, 32'h5E);
    rd0 = data_reads;
    reg_wr(6'h10, 32'h440);
    wait_idle();
    chk("R4 no data reads", 32'(data_reads - rd0), 0);
    reg_rd(6'h04, v); chk("R4 completes", v, 32'h300);
    chk("R4 R6 irq", irq, 1);

    // R9 resume after chain end with appended descriptor
    reg_wr(6'h04, 32'h300);
    put_desc(32'h460, 32'h0, 32'h300, 32'hA00, 32'h4, 32'h4E);
    push_copy(32'h300, 32'hA00, 1);
    mem[32'h440 >> 2] = 32'h460;
    reg_wr(6'h00, 32'h3);
    wait_idle();
    reg_rd(6'h0C, v); chk("R9 resume follows link", v, 32'h460);
    reg_rd(6'h04, v); chk("R9 status", v, 32'h300);
    chk("R6 irq off for no-int desc", irq, 0);
    chk("R9 appended writes seen", 32'(exp_q.size()), 0);

    // R9 resume finding nothing
    reg_wr(6'h04, 32'h300);
    reg_wr(6'h00, 32'h3);
    wait_idle();
    reg_rd(6'h04, v); chk("R9 empty resume eoc only", v, 32'h100);
    reg_rd(6'h0C, v); chk("R9 cur kept", v, 32'h460);

    // R9 resume while running
    reg_wr(6'h04, 32'h300);
    put_desc(32'h480, 32'h0, 32'h100, 32'hB00, 32'd256, 32'h4E);
    put_desc(32'h4A0, 32'h0, 32'h180, 32'hC00, 32'd12, 32'h5E);
    push_copy(32'h100, 32'hB00, 64);
    push_copy(32'h180, 32'hC00, 3);
    reg_wr(6'h10, 32'h480);
    repeat (40) @(negedge clk);
    mem[32'h480 >> 2] = 32'h4A0;
    reg_wr(6'h00, 32'h3);
    wait_idle();
    reg_rd(6'h0C, v); chk("R9 running append cur", v, 32'h4A0);
    chk("R9 running append irq", irq, 1);
    chk("R9 running append writes", 32'(exp_q.size()), 0);

    // R10 disable mid copy
    reg_wr(6'h04, 32'h300);
    put_desc(32'h4C0, 32'h0, 32'h100, 32'hD00, 32'd400, 32'h4E);
    push_copy(32'h100, 32'hD00, 100);
    reg_wr(6'h10, 32'h4C0);
    repeat (60) @(negedge clk);
    reg_wr(6'h00, 32'h0);
    reqs = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (mem_req) reqs++;
    end
    chk("R10 no requests after disable", 32'(reqs), 0);
    reg_rd(6'h04, v); chk("R10 R8 not busy", 32'(v[10]), 0);
    exp_q.delete();
    reg_wr(6'h00, 32'h1);
    reqs = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (mem_req) reqs++;
    end
    chk("R10 re-enable starts nothing", 32'(reqs), 0);
    reg_rd(6'h04, v); chk("R10 idle after re-enable", 32'(v[10]), 0);

    summary();
  end
endmodule